// File: doc/BRIEF.md
# Motor PWM Channel with Double-Buffered Modes

This block is one channel of a motor-drive PWM unit. It watches a free-running timer count and a period value that it shares with its sibling channels, and it compares the count against its own duty value. The result is a left-, right- or center-aligned pulse train. That train is steered onto a minus pin and a plus pin, each with its own output enable. The steering can drive one pin as a half bridge, drive both pins as a complementary full bridge, or drive both pins with the same waveform.

Software configures the channel through one control byte. The byte holds a two-bit output mode, a two-bit alignment mode and a two-bit delay. The two mode fields are written into a shadow copy, and the waveform logic uses only a working copy. The shadow moves into the working copy at once when the timer period is zero, or when every sibling channel is off and this channel's working alignment is also off. Otherwise it moves on the next timer overflow, so a mode change never cuts a running period in half. The delay field takes effect straight away and holds the output back by 0 to 3 timer clocks.

The timer is assumed to advance once per clock. Timer, prescaler and pad drivers live outside this block.

Top module: `mpwm_channel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control byte reads 0x00, the working modes are disabled, and all four pin and enable outputs are 0.
- R2: A read returns the byte most recently written, with bit positions kept: output mode in [7:6], alignment in [5:4], delay in [1:0], and bits [3:2] always read as 0. This holds even while the written modes are not yet active.
- R3: The working output mode selects the pin routing of the pwm signal p. 00 puts p on the minus pin with the plus pin released. 01 puts p on the plus pin with the minus pin released. 10 drives plus = p and minus = not p. 11 drives both pins with p. A released pin has its enable low and its level low.
- R4: When the immediate condition of R5 is false, the working modes stay unchanged except at an edge where tmr_ovf is high. At such an edge they take the shadow value.
- R5: When the period is zero, or when others_off is high and the working alignment is 00, the shadow modes are copied into the working modes at the next clock edge.
- R6: With working alignment 01 (left), p is high while count < duty.
- R7: With working alignment 10 (right), p is high while count >= period - duty, and is always high when duty >= period.
- R8: With working alignment 11 (center), let f = min(count, period-1-count). Then p is high while f < duty/2 (integer halving). With a period of zero, p is low in every alignment.
- R9: With working alignment 00, both pins and both enables are 0 from the next clock on, and the delay pipeline is emptied.
- R10: The pins in clock cycle c+2+d show the routed waveform computed from the count, duty and working modes of cycle c, where d (0 to 3) is the delay field in cycle c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer advances once per clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data (last written value) |
| tmr_cnt | input | CW | Shared timer count |
| tmr_ovf | input | 1 | High in the cycle before the count wraps to zero |
| period | input | CW | Shared timer period; zero forces immediate mode loads |
| duty | input | CW | Duty value of this channel |
| others_off | input | 1 | High when every sibling channel is disabled |
| pin_m | output | 1 | Minus pin level |
| oe_m | output | 1 | Minus pin output enable |
| pin_p | output | 1 | Plus pin level |
| oe_p | output | 1 | Plus pin output enable |

## Verification
The bench first changes modes while sibling channels are running. A design that loaded the shadow at once would switch its waveform in the middle of a period, and the change would show up before the overflow. It then drives duty values of zero and at least the period in left and right alignment. An off-by-one compare here would leave a stray one-clock pulse or a one-clock gap. It also changes the delay field and moves through disabled states. A pipeline that ignored the tap selection or kept stale stages would put edges at the wrong clock, or would release old pulses after the channel is re-enabled. Finally, a zero period is used to check the immediate load, and center alignment is checked on both halves of the fold, where a wrong mirror point would skew the pulse away from the wrap.

// File: rtl/mpwm_pkg.sv
// Package: shared encodings for the motor PWM channel.
// Assumes the control byte layout: output mode [7:6], alignment [5:4], delay [1:0].
package mpwm_pkg;

    // Alignment field encodings.
    typedef enum logic [1:0] {
        AL_OFF    = 2'b00,
        AL_LEFT   = 2'b01,
        AL_RIGHT  = 2'b10,
        AL_CENTER = 2'b11
    } align_e;

    // Output routing encodings.
    typedef enum logic [1:0] {
        OM_HALF_M = 2'b00,
        OM_HALF_P = 2'b01,
        OM_FULL   = 2'b10,
        OM_DUAL   = 2'b11
    } omode_e;

    // Drive vector for both pins, carried through the delay pipeline.
    typedef struct packed {
        logic pin_m;
        logic oe_m;
        logic pin_p;
        logic oe_p;
    } drive_t;

    localparam int DLY_W = 2;

endpackage

// File: rtl/mpwm_ctrl_reg.sv
// Module: control byte with shadow and working copies of the mode fields.
// Assumes the delay field is single buffered and the mode fields are double buffered.
module mpwm_ctrl_reg
    import mpwm_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          period_zero,
    input  logic          others_off,
    input  logic          tmr_ovf,
    output align_e        wk_al,
    output omode_e        wk_om,
    output logic [DW-1:0] dly_sel
);

    align_e sh_al;
    omode_e sh_om;
    logic   load_now;

    // Immediate load when the timer is stopped or the whole unit is idle.
    assign load_now = period_zero | (others_off & (wk_al == AL_OFF));

    // Shadow copy and delay capture the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_al   <= AL_OFF;
            sh_om   <= OM_HALF_M;
            dly_sel <= '0;
        end else if (reg_we) begin
            sh_om   <= omode_e'(reg_wdata[7:6]);
            sh_al   <= align_e'(reg_wdata[5:4]);
            dly_sel <= reg_wdata[DW-1:0];
        end
    end

    // Working copy follows the shadow at once or at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_al <= AL_OFF;
            wk_om <= OM_HALF_M;
        end else if (load_now || tmr_ovf) begin
            wk_al <= sh_al;
            wk_om <= sh_om;
        end
    end

    // Read path shows the shadow, reserved bits as zero.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[7:6] = sh_om;
        reg_rdata[5:4] = sh_al;
        reg_rdata[DW-1:0] = dly_sel;
    end

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata == ($past(reg_wdata) & 8'hF3)));

    a_r4_hold_until_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_now && !tmr_ovf) |=> ($stable(wk_al) && $stable(wk_om)));

    a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        period_zero |=> ({wk_al, wk_om} == $past({sh_al, sh_om})));

endmodule

// File: rtl/mpwm_wave.sv
// Module: combinational compare and pin routing for one channel.
// Assumes tmr_cnt stays below period while period is non-zero.
module mpwm_wave
    import mpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  align_e        wk_al,
    input  omode_e        wk_om,
    input  logic [CW-1:0] tmr_cnt,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] period,
    output drive_t        raw
);

    localparam int XW = CW + 1;

    logic [XW-1:0] cnt_x, duty_x, per_x, mirror, fold, half;
    logic          hi;

    assign cnt_x  = {1'b0, tmr_cnt};
    assign duty_x = {1'b0, duty};
    assign per_x  = {1'b0, period};

    // Fold the up-count into an up/down position for center mode.
    always_comb begin
        mirror = per_x - XW'(1) - cnt_x;
        fold   = (cnt_x < mirror) ? cnt_x : mirror;
        half   = duty_x >> 1;
    end

    // Pulse level per alignment mode.
    always_comb begin
        hi = 1'b0;
        if (period != '0) begin
            unique case (wk_al)
                AL_LEFT:   hi = cnt_x < duty_x;
                AL_RIGHT:  hi = (duty_x >= per_x) || (cnt_x >= per_x - duty_x);
                AL_CENTER: hi = fold < half;
                default:   hi = 1'b0;
            endcase
        end
    end

    // Steer the pulse onto the pins.
    always_comb begin
        raw = '0;
        if (wk_al != AL_OFF) begin
            unique case (wk_om)
                OM_HALF_M: begin raw.pin_m = hi;  raw.oe_m = 1'b1; end
                OM_HALF_P: begin raw.pin_p = hi;  raw.oe_p = 1'b1; end
                OM_FULL:   begin
                    raw.pin_p = hi;  raw.oe_p = 1'b1;
                    raw.pin_m = ~hi; raw.oe_m = 1'b1;
                end
                default:   begin
                    raw.pin_p = hi;  raw.oe_p = 1'b1;
                    raw.pin_m = hi;  raw.oe_m = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/mpwm_delay.sv
// Module: selectable delay line for the drive vector with a registered output.
// Assumes one timer clock per clk; clr empties every stage and the output.
module mpwm_delay
    import mpwm_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] dsel,
    input  drive_t        din,
    output drive_t        dout
);

    localparam int NST = 1 << DW;

    drive_t stage [NST];

    // First stage captures the raw drive vector.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) stage[0] <= '0;
        else               stage[0] <= din;
    end

    // Remaining stages shift one clock each.
    for (genvar k = 1; k < NST; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || clr) stage[k] <= '0;
            else               stage[k] <= stage[k-1];
        end
    end

    // Output register picks the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) dout <= '0;
        else               dout <= stage[dsel];
    end

endmodule

// File: rtl/mpwm_channel.sv
// Module: top of one motor PWM channel.
// Assumes the shared timer raises tmr_ovf in the cycle before it wraps.
module mpwm_channel
    import mpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [CW-1:0] tmr_cnt,
    input  logic          tmr_ovf,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    input  logic          others_off,
    output logic          pin_m,
    output logic          oe_m,
    output logic          pin_p,
    output logic          oe_p
);

    align_e           wk_al;
    omode_e           wk_om;
    logic [DLY_W-1:0] dly_sel;
    drive_t           raw, drv;

    mpwm_ctrl_reg #(.DW(DLY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .period_zero(period == '0),
        .others_off(others_off), .tmr_ovf(tmr_ovf),
        .wk_al(wk_al), .wk_om(wk_om), .dly_sel(dly_sel)
    );

    mpwm_wave #(.CW(CW)) u_wave (
        .wk_al(wk_al), .wk_om(wk_om), .tmr_cnt(tmr_cnt),
        .duty(duty), .period(period), .raw(raw)
    );

    mpwm_delay #(.DW(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .clr(wk_al == AL_OFF),
        .dsel(dly_sel), .din(raw), .dout(drv)
    );

    assign pin_m = drv.pin_m;
    assign oe_m  = drv.oe_m;
    assign pin_p = drv.pin_p;
    assign oe_p  = drv.oe_p;

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_al == AL_OFF) |=> ({pin_m, oe_m, pin_p, oe_p} == 4'b0000));

    a_r3_released_m_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_m |-> !pin_m);

    a_r3_released_p_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_p |-> !pin_p);

endmodule

// File: tb/mpwm_channel_bench.sv
module mpwm_channel_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [CW-1:0] tmr_cnt = '0;
    logic          tmr_ovf;
    logic [CW-1:0] period = '0;
    logic [CW-1:0] duty = '0;
    logic          others_off = 1'b1;
    logic          pin_m, oe_m, pin_p, oe_p;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    assign tmr_ovf = (period != 0) && (tmr_cnt == period - 1);

    mpwm_channel #(.CW(CW)) u_mpwm_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_cnt(tmr_cnt), .tmr_ovf(tmr_ovf),
        .period(period), .duty(duty), .others_off(others_off),
        .pin_m(pin_m), .oe_m(oe_m), .pin_p(pin_p), .oe_p(oe_p)
    );

    // Reference model state (integers and a queue of past drive vectors).
    int         m_sh_al = 0, m_sh_om = 0, m_dly = 0, m_wk_al = 0, m_wk_om = 0;
    logic [3:0] pipe[$] = '{4'h0, 4'h0, 4'h0, 4'h0};
    logic [3:0] exp_drv = 4'h0;

    // Expected {pin_m, oe_m, pin_p, oe_p} from the requirement text.
    function automatic logic [3:0] ref_raw(int al, int om, int c, int du, int p);
        bit h;
        int f;
        if (al == 0) return 4'b0000;
        h = 1'b0;
        if (p != 0) begin
            case (al)
                1: h = c < du;
                2: h = (du >= p) || (c >= p - du);
                default: begin
                    f = (c < p - 1 - c) ? c : p - 1 - c;
                    h = f < du / 2;
                end
            endcase
        end
        case (om)
            0: return {h, 1'b1, 1'b0, 1'b1 & 1'b0};
            1: return {1'b0, 1'b0, h, 1'b1};
            2: return {~h, 1'b1, h, 1'b1};
            default: return {h, 1'b1, h, 1'b1};
        endcase
    endfunction

    // Model advance at each rising edge using the inputs held since the last falling edge.
    always @(posedge clk) begin
        logic [3:0] r;
        if (!rst_n) begin
            m_sh_al = 0; m_sh_om = 0; m_dly = 0; m_wk_al = 0; m_wk_om = 0;
            pipe = '{4'h0, 4'h0, 4'h0, 4'h0};
            exp_drv = 4'h0;
        end else begin
            r = ref_raw(m_wk_al, m_wk_om, int'(tmr_cnt), int'(duty), int'(period));
            exp_drv = (m_wk_al == 0) ? 4'h0 : pipe[m_dly];
            if (m_wk_al == 0) pipe = '{4'h0, 4'h0, 4'h0, 4'h0};
            else begin
                pipe.push_front(r);
                void'(pipe.pop_back());
            end
            if (period == 0 || (others_off && m_wk_al == 0) || tmr_ovf) begin
                m_wk_al = m_sh_al;
                m_wk_om = m_sh_om;
            end
            if (reg_we) begin
                m_sh_om = int'(reg_wdata[7:6]);
                m_sh_al = int'(reg_wdata[5:4]);
                m_dly   = int'(reg_wdata[1:0]);
            end
        end
    end

    // Compare pins against the model, then advance the shared timer, at each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            checks++;
            if ({pin_m, oe_m, pin_p, oe_p} !== exp_drv) begin
                errors++;
                $display("FAIL %s cycle %0d: pins actual=%b expected=%b", tag, cycles,
                         {pin_m, oe_m, pin_p, oe_p}, exp_drv);
            end
        end
        if (period == 0 || tmr_cnt >= period - 1) tmr_cnt <= '0;
        else tmr_cnt <= tmr_cnt + 1'b1;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_val(string t, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", t, act, expv);
        end
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check_val("R1 read", reg_rdata, 8'h00);
        check_val("R1 pins", {4'h0, pin_m, oe_m, pin_p, oe_p}, 8'h00);
        cmp_on = 1'b1;

        // R6: left aligned, full bridge, immediate load while idle (R5)
        period = 20; duty = 7; others_off = 1'b1;
        tag = "R6";
        wr(8'b10_01_11_00);
        // R2: reserved bits read zero
        check_val("R2 readback", reg_rdata, 8'b10_01_00_00);
        run(60);

        // R4: siblings running, mode change deferred to overflow
        others_off = 1'b0;
        tag = "R4";
        wr(8'b10_10_00_00);
        check_val("R2 shadow read", reg_rdata, 8'b10_10_00_00);
        run(30);
        // R7: right aligned
        tag = "R7";
        run(30);
        duty = 0; run(40);
        duty = 25; run(40);
        duty = 5;

        // R8 and R10: center aligned, dual bridge, delay 2
        tag = "R8";
        wr(8'b11_11_00_10);
        run(60);
        duty = 13; run(40);

        // R10: delay changes in every tap
        tag = "R10";
        wr(8'b11_01_00_11); run(45);
        wr(8'b11_01_00_01); run(45);
        wr(8'b11_01_00_00); run(45);

        // R3: half bridge on each pin
        tag = "R3";
        wr(8'b00_01_00_01); run(45);
        wr(8'b01_10_00_10); run(45);
        wr(8'b10_11_00_00); run(45);

        // R9: disable with siblings running, then stay quiet
        tag = "R9";
        wr(8'b10_00_00_11); run(50);
        check_val("R9 pins off", {4'h0, pin_m, oe_m, pin_p, oe_p}, 8'h00);
        // R9: re-enable while idle, stale pipeline must not reappear
        others_off = 1'b1;
        wr(8'b01_01_00_11); run(45);

        // R5: zero period loads at once, pwm held low
        tag = "R5";
        others_off = 1'b0;
        period = 0;
        wr(8'b10_11_00_00); run(10);
        wr(8'b11_01_00_00); run(10);
        period = 21; duty = 9;
        tag = "R8";
        wr(8'b10_11_00_01); run(70);
        check_val("R2 final read", reg_rdata, 8'b10_11_00_01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule